// File: doc/BRIEF.md
# Segment Register Descriptor Cache

This block holds six segment registers for a protected-mode style address unit. Each register pairs a visible 16-bit selector with a hidden copy of a descriptor: a 32-bit base, a 32-bit limit and eleven attribute bits. When a selector is written, the block computes where the matching descriptor sits in a table in memory. It reads the descriptor through a request/response read port and loads the decoded result into that register's hidden part. After that, address translation uses only the cached copy and never goes back to memory.

A translation request names a segment and a 32-bit offset. The block answers one cycle later with the linear address (cached base plus offset, wrapping modulo 2^32), the attributes and the selector, or it raises a fault when the offset lies beyond the cached limit. The table base comes from a configuration input that is registered inside the block.

Selector writes, translation requests and translation results are valid/ready streams. A transfer happens on a rising edge where valid and ready are both high. A selector write is held off while a descriptor fetch is in flight. A translation request is held off while its own segment is being refilled, or while an earlier result is still waiting for its consumer. The result stays stable while `res_ready` is low. The memory read port offers one request at a time. A request is held, with a stable address, until `mem_req_ready` is high. The response has no ready signal and must arrive at least one cycle after its request was accepted.

Top module: `seg_desc_cache`

## Requirements
- R1: After reset every hidden part holds base 0, limit 0xFFFFFFFF and attributes 0, and every selector is 0. Any offset on segments 0 to 5 then translates to itself with no fault, and `sel_ready` and `xl_ready` are high while `res_valid` and `mem_req_valid` are low.
- R2: An accepted selector write to a valid segment starts a fetch. `sel_ready` stays low from the next cycle until the descriptor has been loaded.
- R3: A fetch issues exactly two reads, at table_base + selector*8 and then at that address + 4. The first word is the base. In the second word, bits [19:0] are the raw limit, bit 20 is the granularity flag and bits [31:21] are the attributes.
- R4: With granularity 0 the limit equals the raw limit. With granularity 1 it is the raw limit followed by twelve one bits.
- R5: An accepted translation gives `res_valid` on the next cycle with `res_addr` = base + offset mod 2^32, plus the cached attributes and the visible selector of that segment.
- R6: An offset greater than the cached limit gives `res_fault` = 1 and `res_addr` = 0. An offset equal to the limit does not fault.
- R7: While a fetch for a segment is in flight, translation requests on that segment see `xl_ready` low. With a memory that answers one cycle after each request, they are accepted on the fifth cycle after the selector write and use the new descriptor. Requests on other segments are accepted without delay.
- R8: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS and 5 GS. A translation on code 6 or 7 faults with address 0. A selector write on code 6 or 7 is accepted and issues no read.
- R9: While `res_valid` is high and `res_ready` is low, the result holds stable and `xl_ready` is low.
- R10: A write of the table base affects only fetches started after it. Descriptors already cached keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the descriptor table base |
| cfg_tbl_base | input | 32 | New descriptor table base |
| sel_valid | input | 1 | Selector write valid |
| sel_ready | output | 1 | Selector write ready (no fetch in flight) |
| sel_seg | input | 3 | Segment code of the write |
| sel_value | input | 16 | Selector value (table index) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request ready |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| xl_valid | input | 1 | Translation request valid |
| xl_ready | output | 1 | Translation request ready |
| xl_seg | input | 3 | Segment code of the request |
| xl_off | input | 32 | Offset within the segment |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Translation result ready |
| res_addr | output | 32 | Linear address, 0 on fault |
| res_fault | output | 1 | Limit or segment-code fault |
| res_attr | output | 11 | Cached attribute bits |
| res_sel | output | 16 | Visible selector of the segment |

## Verification
A translation result is due on the cycle after the request is accepted. A descriptor load completes on the fourth rising edge after the selector write is accepted, when each memory read is answered one cycle after it is accepted. A waiting translation on the refilled segment is therefore accepted on the fifth edge. The bench drives and samples on falling edges. It counts the falling edges in which `xl_ready` stays low and compares that count with the expected four, then reads each result exactly one falling edge after its accepting edge. The bench memory logs every request address, so the bench can check the number and order of reads against the table base and the selector.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;
  localparam int unsigned LIN_W         = 32;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned SEL_W         = 16;
  localparam int unsigned NUM_SEG       = 6;
  localparam int unsigned SEG_W         = 3;
  localparam int unsigned LIM_RAW_W     = 20;
  localparam int unsigned GRAN_BIT      = LIM_RAW_W;
  localparam int unsigned ATTR_LSB      = GRAN_BIT + 1;
  localparam int unsigned ATTR_W        = WORD_W - ATTR_LSB;
  localparam int unsigned GRAN_SHIFT    = LIN_W - LIM_RAW_W;
  localparam int unsigned DESC_BYTES_LG = 3;

  typedef enum logic [SEG_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  typedef struct packed {
    logic [LIN_W-1:0]  base;
    logic [LIN_W-1:0]  limit;
    logic [ATTR_W-1:0] attr;
  } seg_hidden_t;

  function automatic seg_hidden_t hidden_reset();
    seg_hidden_t h;
    h.base  = '0;
    h.limit = '1;
    h.attr  = '0;
    return h;
  endfunction

  function automatic seg_hidden_t decode_desc(input logic [WORD_W-1:0] lo,
                                              input logic [WORD_W-1:0] hi);
    seg_hidden_t d;
    logic [LIM_RAW_W-1:0] raw;
    raw    = hi[LIM_RAW_W-1:0];
    d.base = lo;
    if (hi[GRAN_BIT]) d.limit = {raw, {GRAN_SHIFT{1'b1}}};
    else              d.limit = LIN_W'(raw);
    d.attr = hi[ATTR_LSB +: ATTR_W];
    return d;
  endfunction
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LIN_W-1:0]  cfg_tbl_base,
  input  logic              start,
  input  logic [SEG_W-1:0]  start_seg,
  input  logic [SEL_W-1:0]  start_sel,
  output logic              busy,
  output logic [SEG_W-1:0]  busy_seg,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LIN_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              commit,
  output logic [SEG_W-1:0]  commit_seg,
  output seg_hidden_t       commit_desc
);
  typedef enum logic [2:0] {
    F_IDLE, F_REQ_LO, F_WAIT_LO, F_REQ_HI, F_WAIT_HI
  } fstate_e;

  localparam int unsigned      IDX_PAD = LIN_W - SEL_W - DESC_BYTES_LG;
  localparam logic [LIN_W-1:0] HI_STEP = LIN_W'(WORD_W / 8);

  fstate_e           state_q;
  logic [LIN_W-1:0]  tbl_base_q;
  logic [LIN_W-1:0]  desc_addr_q;
  logic [WORD_W-1:0] lo_word_q;
  logic [SEG_W-1:0]  seg_q;
  logic              start_ok;

  assign start_ok = start && (start_seg < SEG_W'(NUM_SEG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= F_IDLE;
      tbl_base_q  <= '0;
      desc_addr_q <= '0;
      lo_word_q   <= '0;
      seg_q       <= '0;
    end else begin
      if (cfg_we) tbl_base_q <= cfg_tbl_base;
      case (state_q)
        F_IDLE: if (start_ok) begin
          seg_q       <= start_seg;
          desc_addr_q <= tbl_base_q +
                         {{IDX_PAD{1'b0}}, start_sel, {DESC_BYTES_LG{1'b0}}};
          state_q     <= F_REQ_LO;
        end
        F_REQ_LO:  if (mem_req_ready) state_q <= F_WAIT_LO;
        F_WAIT_LO: if (mem_rsp_valid) begin
          lo_word_q <= mem_rsp_data;
          state_q   <= F_REQ_HI;
        end
        F_REQ_HI:  if (mem_req_ready) state_q <= F_WAIT_HI;
        F_WAIT_HI: if (mem_rsp_valid) state_q <= F_IDLE;
        default:   state_q <= F_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != F_IDLE);
  assign busy_seg      = seg_q;
  assign mem_req_valid = (state_q == F_REQ_LO) || (state_q == F_REQ_HI);
  assign mem_req_addr  = (state_q == F_REQ_HI) ? desc_addr_q + HI_STEP : desc_addr_q;
  assign commit        = (state_q == F_WAIT_HI) && mem_rsp_valid;
  assign commit_seg    = seg_q;
  assign commit_desc   = decode_desc(lo_word_q, mem_rsp_data);

  // R3: a request waiting on the memory keeps its address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import seg_desc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEG_W-1:0] sel_wseg,
  input  logic [SEL_W-1:0] sel_wval,
  input  logic             commit,
  input  logic [SEG_W-1:0] commit_seg,
  input  seg_hidden_t      commit_desc,
  input  logic [SEG_W-1:0] rd_seg,
  output logic             rd_ok,
  output seg_hidden_t      rd_desc,
  output logic [SEL_W-1:0] rd_sel
);
  seg_hidden_t      hid_q [NUM_SEG];
  logic [SEL_W-1:0] vis_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hid_q[g] <= hidden_reset();
        vis_q[g] <= '0;
      end else begin
        if (sel_we && sel_wseg == SEG_W'(g)) vis_q[g] <= sel_wval;
        if (commit && commit_seg == SEG_W'(g)) hid_q[g] <= commit_desc;
      end
    end
  end

  always_comb begin
    rd_ok   = 1'b0;
    rd_desc = hidden_reset();
    rd_sel  = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_seg == SEG_W'(i)) begin
        rd_ok   = 1'b1;
        rd_desc = hid_q[i];
        rd_sel  = vis_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic [LIN_W-1:0]  xl_off,
  input  logic              seg_blocked,
  input  logic              rd_ok,
  input  seg_hidden_t       rd_desc,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              xl_ready,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [LIN_W-1:0]  res_addr,
  output logic              res_fault,
  output logic [ATTR_W-1:0] res_attr,
  output logic [SEL_W-1:0]  res_sel
);
  logic             accept;
  logic             bad;
  logic [LIN_W-1:0] sum;

  assign xl_ready = !seg_blocked && (!res_valid || res_ready);
  assign accept   = xl_valid && xl_ready;
  assign bad      = !rd_ok || (xl_off > rd_desc.limit);
  assign sum      = rd_desc.base + xl_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_fault <= 1'b0;
      res_attr  <= '0;
      res_sel   <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_fault <= bad;
      res_addr  <= bad ? '0 : sum;
      res_attr  <= rd_desc.attr;
      res_sel   <= rd_sel;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R9: a stalled result does not change
  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_fault));

  // R6: a faulting result carries no address
  a_r6_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_addr == '0);
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LIN_W-1:0]  cfg_tbl_base,
  input  logic              sel_valid,
  output logic              sel_ready,
  input  logic [SEG_W-1:0]  sel_seg,
  input  logic [SEL_W-1:0]  sel_value,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LIN_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              xl_valid,
  output logic              xl_ready,
  input  logic [SEG_W-1:0]  xl_seg,
  input  logic [LIN_W-1:0]  xl_off,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [LIN_W-1:0]  res_addr,
  output logic              res_fault,
  output logic [ATTR_W-1:0] res_attr,
  output logic [SEL_W-1:0]  res_sel
);
  logic             fetch_busy;
  logic [SEG_W-1:0] busy_seg;
  logic             sel_acc;
  logic             commit;
  logic [SEG_W-1:0] commit_seg;
  seg_hidden_t      commit_desc;
  logic             rd_ok;
  seg_hidden_t      rd_desc;
  logic [SEL_W-1:0] rd_sel;
  logic             seg_blocked;

  assign sel_ready   = !fetch_busy;
  assign sel_acc     = sel_valid && sel_ready;
  assign seg_blocked = fetch_busy && (xl_seg == busy_seg);

  seg_fetch u_fetch (
    .clk, .rst_n, .cfg_we, .cfg_tbl_base,
    .start(sel_acc), .start_seg(sel_seg), .start_sel(sel_value),
    .busy(fetch_busy), .busy_seg,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data,
    .commit, .commit_seg, .commit_desc
  );

  seg_bank u_bank (
    .clk, .rst_n,
    .sel_we(sel_acc), .sel_wseg(sel_seg), .sel_wval(sel_value),
    .commit, .commit_seg, .commit_desc,
    .rd_seg(xl_seg), .rd_ok, .rd_desc, .rd_sel
  );

  seg_xlate u_xlate (
    .clk, .rst_n, .xl_valid, .xl_off, .seg_blocked,
    .rd_ok, .rd_desc, .rd_sel, .xl_ready,
    .res_ready, .res_valid, .res_addr, .res_fault, .res_attr, .res_sel
  );

  // R7: no request is taken on a segment that is being refilled
  a_r7_pending_block: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_ready |-> !(fetch_busy && xl_seg == busy_seg));

  // R2: a write to a valid segment starts a memory read and blocks further writes
  a_r2_fetch_starts: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_ready && (sel_seg < SEG_W'(NUM_SEG)) |=> mem_req_valid && !sel_ready);

  // R8: a write to an unused segment code issues no read
  a_r8_invalid_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_ready && (sel_seg >= SEG_W'(NUM_SEG)) |=> !mem_req_valid);
endmodule

// File: tb/seg_desc_cache_test.sv
`timescale 1ns/1ps
module seg_desc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_tbl_base = '0;
  logic        sel_valid = 1'b0;
  logic        sel_ready;
  logic [2:0]  sel_seg = '0;
  logic [15:0] sel_value = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [2:0]  xl_seg = '0;
  logic [31:0] xl_off = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_addr;
  logic        res_fault;
  logic [10:0] res_attr;
  logic [15:0] res_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] tbl_lo [16];
  logic [31:0] tbl_hi [16];
  logic [31:0] tb_base = '0;
  logic [31:0] req_log [64];
  int          req_n = 0;
  bit          pend = 0;
  logic [31:0] pend_addr;

  always #4 clk = ~clk;

  seg_desc_cache uut (.*);

  function automatic logic [31:0] mk_hi(input logic [10:0] attr, input logic gran,
                                        input logic [19:0] raw);
    return {attr, gran, raw};
  endfunction

  function automatic logic [31:0] data_for(input logic [31:0] a);
    logic [31:0] d;
    d = a - tb_base;
    if (d[31:3] < 16) return d[2] ? tbl_hi[d[6:3]] : tbl_lo[d[6:3]];
    return 32'hDEAD_0000 ^ a;
  endfunction

  // memory: answers one cycle after each accepted request
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= data_for(pend_addr);
      pend <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      pend      <= 1;
      pend_addr <= mem_req_addr;
      if (req_n < 64) req_log[req_n] = mem_req_addr;
      req_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sel_write(input logic [2:0] s, input logic [15:0] v);
    sel_valid = 1'b1; sel_seg = s; sel_value = v;
    #1;
    while (!sel_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    sel_valid = 1'b0;
  endtask

  task automatic wait_idle();
    #1;
    while (!sel_ready) begin @(negedge clk); #1; end
  endtask

  task automatic xl(input logic [2:0] s, input logic [31:0] o,
                    output logic [31:0] a, output logic f);
    xl_valid = 1'b1; xl_seg = s; xl_off = o;
    #1;
    while (!xl_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    xl_valid = 1'b0;
    chk("R5 res_valid latency", {31'd0, res_valid}, 32'd1);
    a = res_addr; f = res_fault;
  endtask

  task automatic t_reset();
    logic [31:0] a; logic f;
    chk("R1 sel_ready", {31'd0, sel_ready}, 32'd1);
    chk("R1 xl_ready", {31'd0, xl_ready}, 32'd1);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    for (int s = 0; s < 6; s++) begin
      xl(3'(s), 32'hFFFF_FFFF, a, f);
      chk("R1 flat addr", a, 32'hFFFF_FFFF);
      chk("R1 flat fault", {31'd0, f}, 32'd0);
    end
    xl(3'd5, 32'h0000_1234, a, f);
    chk("R1 flat GS addr", a, 32'h0000_1234);
    chk("R1 attr reset", {21'd0, res_attr}, 32'd0);
  endtask

  task automatic t_load();
    logic [31:0] a; logic f; int n0;
    cfg_tbl_base = 32'h0000_1000; cfg_we = 1'b1; tb_base = 32'h0000_1000;
    @(negedge clk); cfg_we = 1'b0;
    tbl_lo[2] = 32'h0040_0000; tbl_hi[2] = mk_hi(11'h09A, 1'b0, 20'h0FFFF);
    n0 = req_n;
    sel_write(3'd3, 16'd2);
    #1;
    chk("R2 sel_ready low after write", {31'd0, sel_ready}, 32'd0);
    wait_idle();
    chk("R3 read count", req_n - n0, 32'd2);
    chk("R3 low word addr", req_log[n0], 32'h0000_1010);
    chk("R3 high word addr", req_log[n0+1], 32'h0000_1014);
    xl(3'd3, 32'h0000_0100, a, f);
    chk("R5 DS addr", a, 32'h0040_0100);
    chk("R5 DS attr", {21'd0, res_attr}, 32'h09A);
    chk("R5 DS selector", {16'd0, res_sel}, 32'd2);
    xl(3'd3, 32'h0000_FFFF, a, f);
    chk("R6 at limit fault", {31'd0, f}, 32'd0);
    chk("R6 at limit addr", a, 32'h0040_FFFF);
    xl(3'd3, 32'h0001_0000, a, f);
    chk("R6 over limit fault", {31'd0, f}, 32'd1);
    chk("R6 over limit addr", a, 32'd0);
  endtask

  task automatic t_gran();
    logic [31:0] a; logic f;
    tbl_lo[3] = 32'hFFFF_F000; tbl_hi[3] = mk_hi(11'h193, 1'b1, 20'h00001);
    sel_write(3'd4, 16'd3);
    wait_idle();
    xl(3'd4, 32'h0000_1FFF, a, f);
    chk("R4 scaled limit edge fault", {31'd0, f}, 32'd0);
    chk("R5 wrap addr", a, 32'h0000_0FFF);
    xl(3'd4, 32'h0000_2000, a, f);
    chk("R4 scaled limit over", {31'd0, f}, 32'd1);
  endtask

  task automatic t_stall();
    logic [31:0] a; logic f; int cnt;
    tbl_lo[5] = 32'h2000_0000; tbl_hi[5] = mk_hi(11'h2AB, 1'b1, 20'hFFFFF);
    sel_write(3'd2, 16'd5);
    xl_valid = 1'b1; xl_seg = 3'd2; xl_off = 32'h10;
    #1;
    chk("R7 pending seg not ready", {31'd0, xl_ready}, 32'd0);
    cnt = 0;
    while (!xl_ready) begin cnt++; @(negedge clk); #1; end
    chk("R7 stall length", cnt, 32'd4);
    @(negedge clk); xl_valid = 1'b0;
    chk("R7 new base used", res_addr, 32'h2000_0010);
    chk("R7 new attr", {21'd0, res_attr}, 32'h2AB);
    sel_write(3'd0, 16'd5);
    xl_valid = 1'b1; xl_seg = 3'd1; xl_off = 32'h7;
    #1;
    chk("R7 other seg ready", {31'd0, xl_ready}, 32'd1);
    @(negedge clk); xl_valid = 1'b0;
    chk("R7 other seg addr", res_addr, 32'h7);
    wait_idle();
    xl(3'd0, 32'h10, a, f);
    chk("R7 ES after load", a, 32'h2000_0010);
  endtask

  task automatic t_invalid();
    logic [31:0] a; logic f; int n0;
    xl(3'd6, 32'h0, a, f);
    chk("R8 code 6 fault", {31'd0, f}, 32'd1);
    chk("R8 code 6 addr", a, 32'd0);
    xl(3'd7, 32'h55, a, f);
    chk("R8 code 7 fault", {31'd0, f}, 32'd1);
    n0 = req_n;
    sel_write(3'd7, 16'd3);
    repeat (4) @(negedge clk);
    chk("R8 no read for code 7", req_n - n0, 32'd0);
    #1;
    chk("R8 sel_ready stays", {31'd0, sel_ready}, 32'd1);
  endtask

  task automatic t_hold();
    logic [31:0] a; logic f;
    res_ready = 1'b0;
    xl(3'd3, 32'h100, a, f);
    chk("R9 first result", a, 32'h0040_0100);
    xl_valid = 1'b1; xl_seg = 3'd1; xl_off = 32'h200;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 xl_ready low while held", {31'd0, xl_ready}, 32'd0);
      chk("R9 result held", res_addr, 32'h0040_0100);
      @(negedge clk);
    end
    res_ready = 1'b1;
    #1;
    chk("R9 ready after release", {31'd0, xl_ready}, 32'd1);
    @(negedge clk); xl_valid = 1'b0;
    chk("R9 next result", res_addr, 32'h200);
  endtask

  task automatic t_cfg();
    logic [31:0] a; logic f; int n0;
    cfg_tbl_base = 32'h0000_8000; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0; tb_base = 32'h0000_8000;
    tbl_lo[1] = 32'h0300_0000; tbl_hi[1] = mk_hi(11'h011, 1'b0, 20'h000FF);
    n0 = req_n;
    sel_write(3'd5, 16'd1);
    wait_idle();
    chk("R10 new table addr", req_log[n0], 32'h0000_8008);
    xl(3'd5, 32'h20, a, f);
    chk("R10 GS addr", a, 32'h0300_0020);
    xl(3'd3, 32'h100, a, f);
    chk("R10 DS kept", a, 32'h0040_0100);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin tbl_lo[i] = '0; tbl_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_gran();
    t_stall();
    t_invalid();
    t_hold();
    t_cfg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R7 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule